// File: doc/BRIEF.md
# Cascaded Interrupt Register Controller

This block gathers event pulses from eleven second-level interrupt groups and rolls them up into one first-level master register that drives a single interrupt line. Each group has four 32-bit registers: a read-only status register that shows the raw event word seen at the last clock edge, a mask register, an identity register that latches events, and an enable register. An event latches into identity only while its mask bit is clear. Identity bits are cleared by writing ones to them. Mask and enable writes replace the whole word.

The master register is not stored state, apart from its top bit. Bits 30..0 are a live summary of the groups, each bit being the OR of (identity AND enable) over one half-word or one full word of one group. Bit 31 is the only writable bit and acts as a global enable. The interrupt output is high when the global enable is set and any summary bit is set.

Software reaches the registers over a simple word bus. Group `g` sits at address `g*0x10`, with status at +0x0, mask at +0x4, identity at +0x8 and enable at +0xC. The master register sits at 0x200. A small bus state machine has two states. In BUS_IDLE, no read response is pending. In BUS_RESP, the read data captured at the previous edge is valid. Every accepted read moves the machine to BUS_RESP for the next cycle. Any cycle without a read returns it to BUS_IDLE.

Top module: `irqc_top`

## Requirements
- R1: After reset every mask, identity, enable and status word and the global enable are 0, `irq_o` is 0, and a read of the master register returns 0.
- R2: A 1 on an event input sets the matching identity bit at the next clock edge only if that group's mask bit is 0. A masked event is discarded and does not appear when the mask bit is later cleared.
- R3: A write to an identity register (offset 0x8) clears each bit written as 1 and keeps the others. If an event arrives on a bit in the same cycle that the bit is being cleared, the bit stays set.
- R4: A write to a mask register (offset 0x4) or an enable register (offset 0xC) replaces the whole word, and the written value reads back.
- R5: The status register (offset 0x0) reads back the raw event word sampled at the most recent clock edge, whatever the mask. Writes to it have no effect.
- R6: The master summary bits follow (identity AND enable) with this mapping:
  - group 0 bits 15..0 drive bit 0, and bits 31..16 drive bit 1;
  - group 1 bits 15..0 drive bit 2, and bits 31..16 drive bit 3;
  - group 2 bits 15..0 drive bit 4;
  - group 3 bits 15..0 drive bit 6;
  - the full words of groups 4 to 10 drive bits 16, 17, 18, 20, 22, 23 and 30.
  - All other master bits below 31 read 0.
- R7: The upper half-words of groups 2 and 3 never set any master bit.
- R8: A write to the master register (0x200) stores only bit 31 as the global enable. All other written bits are ignored, and a read returns the stored enable in bit 31 with the live summary in bits 30..0.
- R9: `irq_o` is 1 exactly when the global enable is set and at least one summary bit is set. Clearing the last pending identity bit, or dropping the enable, lowers `irq_o` right after the edge that applies the write.
- R10: A read of an address that maps to no register, including any address whose two low bits are not 0, returns 0. A write to such an address changes nothing.
- R11: A read request accepted at an edge produces `bus_rvalid` = 1 and the read data during the following cycle. `bus_rvalid` is 0 after any cycle without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 352 | Event pulses, group g on bits [32g+31:32g] |
| bus_req | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench targets several corner cases, and each has a clear failure signature:
- Event and clear on the same bit: a design that lets the clear win loses an interrupt.
- Masked event followed by unmasking: a design that queues masked events raises a stale identity bit.
- Upper halves of the low-half-only groups: a design that maps them by mistake fires the master line spuriously.
- Writes to master bits other than bit 31: a design that stores them reports summary bits that nothing drives.
- Misaligned and out-of-range addresses: a loose decoder aliases them onto real registers.

Random traffic mixes sparse events with mask, enable, clear and master writes. Every cycle, the bench compares the output line and each read value against its own register model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_GROUPS = 11;
    localparam int DATA_W     = 32;
    localparam int SUM_W      = DATA_W - 1;
    localparam int HALF_W     = DATA_W / 2;
    localparam int GSEL_W     = $clog2(NUM_GROUPS);

    // How much of a group's word feeds the master summary
    typedef enum logic [1:0] {
        SPAN_WORD   = 2'd0,
        SPAN_HALVES = 2'd1,
        SPAN_LOW    = 2'd2
    } span_e;

    // Register offsets inside a group, address bits [3:2]
    typedef enum logic [1:0] {
        OFS_STATUS = 2'd0,
        OFS_MASK   = 2'd1,
        OFS_IDENT  = 2'd2,
        OFS_ENABLE = 2'd3
    } reg_ofs_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    function automatic span_e group_span(input int g);
        if (g < 2)      return SPAN_HALVES;
        else if (g < 4) return SPAN_LOW;
        else            return SPAN_WORD;
    endfunction

    // Master bit fed by the low half (or whole word) of group g
    function automatic int low_bit(input int g);
        case (g)
            0:       return 0;
            1:       return 2;
            2:       return 4;
            3:       return 6;
            4:       return 16;
            5:       return 17;
            6:       return 18;
            7:       return 20;
            8:       return 22;
            9:       return 23;
            default: return 30;
        endcase
    endfunction

    // Master bit fed by the high half of a split group
    function automatic int high_bit(input int g);
        return 2 * g + 1;
    endfunction

endpackage

// File: rtl/irqc_group.sv
module irqc_group
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt,
    input  logic              wr_mask,
    input  logic              wr_ident,
    input  logic              wr_enable,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] ident_q,
    output logic [DATA_W-1:0] enable_q
);

    logic [DATA_W-1:0] clr_bits;
    logic [DATA_W-1:0] set_bits;
    logic [DATA_W-1:0] ident_d;

    always_comb begin
        clr_bits = wr_ident ? wdata : '0;
        // mask in force before this edge gates the events
        set_bits = evt & ~mask_q;
        // set after clear: a simultaneous event survives
        ident_d  = (ident_q & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
            ident_q  <= '0;
            enable_q <= '0;
        end else begin
            status_q <= evt;
            ident_q  <= ident_d;
            if (wr_mask)   mask_q   <= wdata;
            if (wr_enable) enable_q <= wdata;
        end
    end

endmodule

// File: rtl/irqc_summary.sv
module irqc_summary
    import irqc_pkg::*;
(
    input  logic [NUM_GROUPS-1:0][DATA_W-1:0] pend,
    output logic [SUM_W-1:0]                  summary
);

    logic [NUM_GROUPS-1:0][SUM_W-1:0] contrib;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_map
        localparam span_e SPAN = group_span(g);
        localparam int    LO   = low_bit(g);
        localparam logic [DATA_W-1:0] LO_MASK =
            (SPAN == SPAN_WORD) ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

        if (SPAN == SPAN_HALVES) begin : g_split
            localparam int HI = high_bit(g);
            always_comb begin
                contrib[g]     = '0;
                contrib[g][LO] = |(pend[g] & LO_MASK);
                contrib[g][HI] = |(pend[g] & ~LO_MASK);
            end
        end else begin : g_single
            always_comb begin
                contrib[g]     = '0;
                contrib[g][LO] = |(pend[g] & LO_MASK);
            end
        end
    end

    always_comb begin
        summary = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            summary = summary | contrib[g];
        end
    end

endmodule

// File: rtl/irqc_bus.sv
module irqc_bus
    import irqc_pkg::*;
#(
    parameter int                ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] MASTER_ADDR = 12'h200
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [NUM_GROUPS-1:0][DATA_W-1:0] rd_status,
    input  logic [NUM_GROUPS-1:0][DATA_W-1:0] rd_mask,
    input  logic [NUM_GROUPS-1:0][DATA_W-1:0] rd_ident,
    input  logic [NUM_GROUPS-1:0][DATA_W-1:0] rd_enable,
    input  logic [SUM_W-1:0]                summary,
    input  logic                            master_en,
    output logic [NUM_GROUPS-1:0]           wr_mask,
    output logic [NUM_GROUPS-1:0]           wr_ident,
    output logic [NUM_GROUPS-1:0]           wr_enable,
    output logic                            wr_master,
    output logic [DATA_W-1:0]               rdata,
    output logic                            rvalid
);

    localparam int IDX_W = ADDR_W - 4;

    bus_state_e        state_q, state_d;
    logic [IDX_W-1:0]  grp_idx;
    logic [GSEL_W-1:0] sel;
    reg_ofs_e          ofs;
    logic              grp_hit, mst_hit, rd_acc;
    logic [DATA_W-1:0] rd_word;

    always_comb begin
        grp_idx = addr[ADDR_W-1:4];
        sel     = grp_idx[GSEL_W-1:0];
        ofs     = reg_ofs_e'(addr[3:2]);
        grp_hit = (addr[1:0] == 2'b00) && (grp_idx < IDX_W'(NUM_GROUPS));
        mst_hit = (addr == MASTER_ADDR);
        rd_acc  = req && !we;
    end

    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            wr_mask[g]   = req && we && grp_hit && (int'(sel) == g) && (ofs == OFS_MASK);
            wr_ident[g]  = req && we && grp_hit && (int'(sel) == g) && (ofs == OFS_IDENT);
            wr_enable[g] = req && we && grp_hit && (int'(sel) == g) && (ofs == OFS_ENABLE);
        end
        wr_master = req && we && mst_hit;
    end

    always_comb begin
        rd_word = '0;
        if (mst_hit) begin
            rd_word = {master_en, summary};
        end else if (grp_hit) begin
            unique case (ofs)
                OFS_STATUS: rd_word = rd_status[sel];
                OFS_MASK:   rd_word = rd_mask[sel];
                OFS_IDENT:  rd_word = rd_ident[sel];
                OFS_ENABLE: rd_word = rd_enable[sel];
            endcase
        end
    end

    // next-state logic: any accepted read leads to a response cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd_acc ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_acc ? BUS_RESP : BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_acc) rdata <= rd_word;
        else             rdata <= '0;
    end

    assign rvalid = (state_q == BUS_RESP);

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int                ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] MASTER_ADDR = 12'h200
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_GROUPS*DATA_W-1:0] evt_i,
    input  logic                         bus_req,
    input  logic                         bus_we,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic                         bus_rvalid,
    output logic                         irq_o
);

    logic [NUM_GROUPS-1:0][DATA_W-1:0] status_w, mask_w, ident_w, enable_w, pend_w;
    logic [NUM_GROUPS-1:0]             wr_mask, wr_ident, wr_enable;
    logic                              wr_master;
    logic                              master_en;
    logic [SUM_W-1:0]                  summary;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        irqc_group u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (evt_i[g*DATA_W +: DATA_W]),
            .wr_mask   (wr_mask[g]),
            .wr_ident  (wr_ident[g]),
            .wr_enable (wr_enable[g]),
            .wdata     (bus_wdata),
            .status_q  (status_w[g]),
            .mask_q    (mask_w[g]),
            .ident_q   (ident_w[g]),
            .enable_q  (enable_w[g])
        );
        assign pend_w[g] = ident_w[g] & enable_w[g];
    end

    irqc_summary u_sum (
        .pend    (pend_w),
        .summary (summary)
    );

    irqc_bus #(
        .ADDR_W      (ADDR_W),
        .MASTER_ADDR (MASTER_ADDR)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (bus_req),
        .we        (bus_we),
        .addr      (bus_addr),
        .rd_status (status_w),
        .rd_mask   (mask_w),
        .rd_ident  (ident_w),
        .rd_enable (enable_w),
        .summary   (summary),
        .master_en (master_en),
        .wr_mask   (wr_mask),
        .wr_ident  (wr_ident),
        .wr_enable (wr_enable),
        .wr_master (wr_master),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         master_en <= 1'b0;
        else if (wr_master) master_en <= bus_wdata[DATA_W-1];
    end

    assign irq_o = master_en && (|summary);

endmodule

// File: rtl/irqc_top_chk.sv
module irqc_top_chk #(
    parameter int                ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] MASTER_ADDR = 12'h200,
    parameter int                NGROUPS     = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wr_top_bit,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic              irq_o,
    input logic              master_en
);

    logic is_master, is_unmapped;
    assign is_master   = (bus_addr == MASTER_ADDR);
    assign is_unmapped = !is_master &&
        ((bus_addr[1:0] != 2'b00) || (int'(bus_addr[ADDR_W-1:4]) >= NGROUPS));

    // R11
    rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    // R11
    rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !bus_rvalid);

    // R10
    unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && is_unmapped) |=> (bus_rdata == 32'h0));

    // R8
    master_enable_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && is_master) |=> (master_en == $past(wr_top_bit)));

    // R9
    disable_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && is_master && !wr_top_bit) |=> !irq_o);

    // R8
    master_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_we && is_master) |=> $stable(master_en));

endmodule

bind irqc_top irqc_top_chk #(
    .ADDR_W      (ADDR_W),
    .MASTER_ADDR (MASTER_ADDR),
    .NGROUPS     (irqc_pkg::NUM_GROUPS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .wr_top_bit (bus_wdata[31]),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .irq_o      (irq_o),
    .master_en  (master_en)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int NG         = 11;
    localparam int EVW        = NG * 32;
    localparam logic [11:0] MADDR = 12'h200;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [EVW-1:0]  evt_i = '0;
    logic            bus_req = 1'b0;
    logic            bus_we = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            bus_rvalid;
    logic            irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] last_rd;

    logic [31:0] m_stat [NG];
    logic [31:0] m_mask [NG];
    logic [31:0] m_id   [NG];
    logic [31:0] m_en   [NG];
    logic        m_men;

    irqc_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .irq_o      (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [30:0] exp_summary();
        logic [30:0] s = '0;
        logic [31:0] p [NG];
        for (int g = 0; g < NG; g++) p[g] = m_id[g] & m_en[g];
        s[0]  = |p[0][15:0];
        s[1]  = |p[0][31:16];
        s[2]  = |p[1][15:0];
        s[3]  = |p[1][31:16];
        s[4]  = |p[2][15:0];
        s[6]  = |p[3][15:0];
        s[16] = |p[4];
        s[17] = |p[5];
        s[18] = |p[6];
        s[20] = |p[7];
        s[22] = |p[8];
        s[23] = |p[9];
        s[30] = |p[10];
        return s;
    endfunction

    // group index for an aligned in-range address, else -1
    function automatic int grp_of(input logic [11:0] a);
        if (a[1:0] != 2'b00) return -1;
        if (int'(a[11:4]) >= NG) return -1;
        return int'(a[11:4]);
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int g;
        if (a == MADDR) return {m_men, exp_summary()};
        g = grp_of(a);
        if (g < 0) return 32'h0;
        case (a[3:2])
            2'd0: return m_stat[g];
            2'd1: return m_mask[g];
            2'd2: return m_id[g];
            default: return m_en[g];
        endcase
    endfunction

    task automatic cycle(input logic [EVW-1:0] ev, input bit rq, input bit we,
                         input logic [11:0] a, input logic [31:0] d, input string tag);
        logic [31:0] exp_rd;
        int g;
        @(negedge clk);
        evt_i = ev; bus_req = rq; bus_we = we; bus_addr = a; bus_wdata = d;
        exp_rd = exp_read(a);
        @(posedge clk);
        g = grp_of(a);
        for (int k = 0; k < NG; k++) begin
            logic [31:0] clr;
            clr = (rq && we && g == k && a[3:2] == 2'd2) ? d : 32'h0;
            m_id[k]   = (m_id[k] & ~clr) | (ev[k*32 +: 32] & ~m_mask[k]);
            m_stat[k] = ev[k*32 +: 32];
        end
        if (rq && we && g >= 0 && a[3:2] == 2'd1) m_mask[g] = d;
        if (rq && we && g >= 0 && a[3:2] == 2'd3) m_en[g]   = d;
        if (rq && we && a == MADDR) m_men = d[31];
        #1;
        chk(irq_o === (m_men && (|exp_summary())), "R9 irq_o", {31'h0, irq_o},
            {31'h0, m_men && (|exp_summary())});
        chk(bus_rvalid === (rq && !we), "R11 rvalid", {31'h0, bus_rvalid}, {31'h0, rq && !we});
        if (rq && !we) begin
            last_rd = bus_rdata;
            chk(bus_rdata === exp_rd, tag, bus_rdata, exp_rd);
        end
        evt_i = '0; bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        cycle('0, 1'b1, 1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        cycle('0, 1'b1, 1'b0, a, 32'h0, tag);
    endtask

    function automatic logic [EVW-1:0] one_evt(input int g, input int b);
        logic [EVW-1:0] v = '0;
        v[g*32 + b] = 1'b1;
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1357_2468));
        for (int g = 0; g < NG; g++) begin
            m_stat[g] = '0; m_mask[g] = '0; m_id[g] = '0; m_en[g] = '0;
        end
        m_men = 1'b0;
        #(CLK_PERIOD * 3);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(irq_o === 1'b0, "R1 irq after reset", {31'h0, irq_o}, 32'h0);
        rd(MADDR, "R1 master after reset");
        chk(last_rd == 32'h0, "R1 master zero", last_rd, 32'h0);
        rd(12'h004, "R1 mask after reset");
        rd(12'h0A8, "R1 ident after reset");

        // R4 full replacement
        wr(12'h04C, 32'hFFFF_FFFF, "R4");
        wr(12'h04C, 32'h0000_00F0, "R4");
        rd(12'h04C, "R4 enable readback");
        chk(last_rd == 32'h0000_00F0, "R4 enable value", last_rd, 32'h0000_00F0);
        wr(12'h04C, 32'hFFFF_FFFF, "R4");
        wr(MADDR, 32'h8000_0000, "R8");

        // R2 event latches, raises master bit 16
        cycle(one_evt(4, 3), 1'b0, 1'b0, '0, '0, "R2");
        rd(12'h048, "R2 ident after event");
        chk(last_rd == 32'h8, "R2 ident value", last_rd, 32'h8);
        rd(MADDR, "R6 master bit16");
        chk(last_rd == 32'h8001_0000, "R6 master value", last_rd, 32'h8001_0000);

        // R3 W1C then same-cycle event+clear
        wr(12'h048, 32'h8, "R3 clear");
        chk(irq_o === 1'b0, "R9 irq drops after clear", {31'h0, irq_o}, 32'h0);
        cycle(one_evt(4, 5), 1'b1, 1'b1, 12'h048, 32'h20, "R3 race");
        rd(12'h048, "R3 event wins");
        chk(last_rd == 32'h20, "R3 event wins value", last_rd, 32'h20);
        wr(12'h048, 32'hFFFF_FFFF, "R3 clear all");

        // R2 masked event dropped, not replayed
        wr(12'h054, 32'h1, "R2 mask");
        wr(12'h05C, 32'hFFFF_FFFF, "R2 enable");
        cycle(one_evt(5, 0), 1'b0, 1'b0, '0, '0, "R2");
        wr(12'h054, 32'h0, "R2 unmask");
        rd(12'h058, "R2 masked dropped");
        chk(last_rd == 32'h0, "R2 masked value", last_rd, 32'h0);

        // R5 status
        cycle(one_evt(5, 0) | one_evt(5, 9), 1'b0, 1'b0, '0, '0, "R5");
        wr(12'h050, 32'hDEAD_BEEF, "R5 write ignored");
        cycle(one_evt(5, 2), 1'b1, 1'b0, 12'h050, '0, "R5 status sample");
        wr(12'h058, 32'hFFFF_FFFF, "R5 cleanup");

        // R6 half-word mapping on group 0 and 1
        wr(12'h00C, 32'hFFFF_FFFF, "R6");
        wr(12'h01C, 32'hFFFF_FFFF, "R6");
        cycle(one_evt(0, 20) | one_evt(1, 3), 1'b0, 1'b0, '0, '0, "R6");
        rd(MADDR, "R6 halves");
        chk(last_rd == 32'h8000_0006, "R6 halves value", last_rd, 32'h8000_0006);
        wr(12'h008, 32'hFFFF_FFFF, "R6");
        wr(12'h018, 32'hFFFF_FFFF, "R6");

        // R7 upper half of groups 2 and 3
        wr(12'h02C, 32'hFFFF_FFFF, "R7");
        wr(12'h03C, 32'hFFFF_FFFF, "R7");
        cycle(one_evt(2, 20) | one_evt(3, 31), 1'b0, 1'b0, '0, '0, "R7");
        rd(MADDR, "R7 no master bit");
        chk(last_rd == 32'h8000_0000, "R7 master value", last_rd, 32'h8000_0000);
        chk(irq_o === 1'b0, "R7 irq low", {31'h0, irq_o}, 32'h0);
        cycle(one_evt(10, 7), 1'b0, 1'b0, '0, '0, "R6");
        wr(12'h0AC, 32'hFFFF_FFFF, "R6");
        rd(MADDR, "R6 bit30");

        // R8 master writes
        wr(MADDR, 32'h7FFF_FFFF, "R8");
        rd(MADDR, "R8 only bit31");
        chk(last_rd == 32'h4000_0000, "R8 master value", last_rd, 32'h4000_0000);
        wr(MADDR, 32'hFFFF_FFFF, "R8");

        // R10 unmapped
        wr(12'h0B4, 32'hFFFF_FFFF, "R10 write");
        wr(12'h046, 32'hFFFF_FFFF, "R10 misaligned write");
        rd(12'h0B4, "R10 unmapped read");
        rd(12'h202, "R10 misaligned master read");
        rd(12'h044, "R10 mask untouched");
        rd(12'hFF0, "R10 high read");

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [EVW-1:0] ev;
            int op;
            logic [11:0] a;
            logic [31:0] d;
            for (int g = 0; g < NG; g++) ev[g*32 +: 32] = $urandom & $urandom & $urandom;
            op = $urandom % 8;
            a  = {4'h0, 4'($urandom % 13), 2'($urandom % 4), 2'b00};
            if (($urandom % 10) == 0) a[1:0] = 2'($urandom);
            d  = $urandom;
            case (op)
                0, 1: cycle(ev, 1'b1, 1'b0, a, 32'h0, "R2 random read");
                2:    cycle(ev, 1'b1, 1'b1, a, d, "R4 random write");
                3:    cycle(ev, 1'b1, 1'b0, MADDR, 32'h0, "R6 random master read");
                4:    cycle(ev, 1'b1, 1'b1, MADDR, d, "R8 random master write");
                5:    cycle(ev, 1'b1, 1'b1, {a[11:4], 4'h8}, d | (d >> 1), "R3 random clear");
                default: cycle(ev, 1'b0, 1'b0, a, d, "R9 idle");
            endcase
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule